// File: doc/BRIEF.md
# Word DMA Engine with End-of-Transfer Arbitration

This block moves 16-bit words between a bulk endpoint buffer and system memory. It also decides when a transfer is over. Software first writes a byte count and a start address. It then writes a configuration word that enables the engine. The configuration word also chooses the endpoint direction and which end conditions are armed.

On each word beat the engine steps the address by two and lowers the remaining byte count by two. A transfer can end in three ways:
- the counter is used up;
- a short packet is seen;
- software clears the enable bit.

A counter end or a short-packet end raises a one-cycle interrupt and drops the enable bit on its own. A software disable stops the engine silently. In every case a sticky status bit records the reason, and software clears these bits by writing ones.

The endpoint side and the memory side are plain request/acknowledge ports. A beat is a cycle in which `mem_req` and `mem_ack` are both high. `ep_ack` marks that same beat towards the endpoint.

Top module: `dma_eot_engine`

## Requirements
- R1: When `cfg_wdata[0]` (enable) is written as 1 while the engine is idle, the working counter loads from the byte-count register and `mem_addr` loads from the base-address register. Both take effect in the following cycle.
- R2: `mem_req` is high only while the engine is enabled and `ep_req` is high. Each beat raises `mem_addr` by 2 and lowers the working count by 2, saturating at 0.
- R3: With counter end armed (`cfg_wdata[1]`), the transfer ends after the beat that takes the count to zero, and sets `status[0]`. A count of 64 takes exactly 32 beats.
- R4: `mem_be` is `2'b01` on a beat whose remaining count is 1, and `2'b11` otherwise.
- R5: With short-packet end armed (`cfg_wdata[2]`) and direction OUT (`cfg_wdata[3]`=1), a beat with `ep_short` high is the last one and sets `status[1]`. Without counter end armed, an OUT transfer ignores the count.
- R6: With short-packet end armed and direction IN (`cfg_wdata[3]`=0), the transfer ends on the beat that takes the count to zero and sets `status[1]`. `ep_flush` pulses for one cycle only if that beat leaves the current packet of `MPS`=64 bytes partly filled.
- R7: Writing enable as 0 to a running engine stops requests from the next cycle, sets `status[2]`, and gives no interrupt.
- R8: A counter or short-packet end drives `irq` high for exactly the one cycle after the final beat, with `busy` already low.
- R9: When counter and short-packet ends fall on the same beat, both `status[0]` and `status[1]` are set and only one `irq` pulse is given.
- R10: Writing `stat_clr_data` with `stat_clr_wr` clears exactly the status bits written as 1. If a set and a clear hit the same bit in one cycle, the set wins.
- R11: After reset, `busy`, `irq`, `ep_flush`, `mem_req`, `status` and `mem_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | [0] enable, [1] counter end, [2] short end, [3] direction OUT |
| cnt_wr | input | 1 | Byte-count write strobe |
| cnt_wdata | input | CW | Programmed byte count |
| base_wr | input | 1 | Base-address write strobe |
| base_wdata | input | AW | Start address |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_data | input | 3 | Status bits to clear |
| ep_req | input | 1 | Endpoint has a word or space for one |
| ep_short | input | 1 | Current OUT word ends a short packet |
| ep_ack | output | 1 | Word beat done |
| ep_flush | output | 1 | Send partial IN buffer as short packet |
| mem_req | output | 1 | Memory word request |
| mem_ack | input | 1 | Memory accepts the word |
| mem_addr | output | AW | Current word address |
| mem_be | output | 2 | Byte enables of the current word |
| busy | output | 1 | Engine enabled |
| status | output | 3 | [0] counter end, [1] short end, [2] disabled |
| irq | output | 1 | End-of-transfer interrupt pulse |

## Verification
The hardest states to reach are those where two events share one clock edge:
- A counter end and a short end falling on the same beat. The stimulus reaches this from the ports with an OUT transfer whose short word is timed to be the last counted word, and with an IN transfer that has both ends armed.
- A status clear landing on the very edge that sets the same bit. The stimulus reaches this by holding `ep_req` low until the clear strobe and the single beat can be released together.

A silent disable needs the transfer frozen at a known word count. The stimulus freezes it by dropping `ep_req` before the write of enable as 0.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;

    typedef struct packed {
        logic dir_out;
        logic short_eot;
        logic cnt_eot;
        logic enable;
    } dma_cfg_t;

    typedef struct packed {
        logic disabled;
        logic short_pkt;
        logic counter;
    } eot_stat_t;

    localparam int WORD_BYTES = 2;

    function automatic logic [1:0] beat_bytes(input logic odd_tail);
        return odd_tail ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          beat,
    input  logic          limited,
    output logic [1:0]    be,
    output logic [1:0]    bytes,
    output logic          last,
    output logic          exhausted
);
    import dma_eot_pkg::*;

    localparam logic [CW-1:0] STEP = CW'(WORD_BYTES);

    logic [CW-1:0] rem_q;
    logic          odd_tail;

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (load)
            rem_q <= load_val;
        else if (beat)
            rem_q <= (rem_q > STEP) ? rem_q - STEP : '0;
    end

    always_comb begin
        odd_tail  = (rem_q == CW'(1));
        be        = odd_tail ? 2'b01 : 2'b11;
        bytes     = beat_bytes(odd_tail);
        last      = (rem_q != '0) && (rem_q <= STEP);
        exhausted = limited && (rem_q == '0);
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          beat,
    output logic [AW-1:0] addr
);
    import dma_eot_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (beat)
            addr <= addr + AW'(WORD_BYTES);
    end
endmodule

// File: rtl/dma_pkt_fill.sv
module dma_pkt_fill #(
    parameter int MPS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       beat,
    input  logic [1:0] bytes,
    output logic       mid_after
);
    localparam int PW = $clog2(MPS) + 1;

    logic [PW-1:0] fill_q, sum, fill_nx;

    always_comb begin
        sum       = fill_q + PW'(bytes);
        fill_nx   = (sum >= PW'(MPS)) ? sum - PW'(MPS) : sum;
        mid_after = (fill_nx != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            fill_q <= '0;
        else if (beat)
            fill_q <= fill_nx;
    end
endmodule

// File: rtl/dma_eot_arbiter.sv
module dma_eot_arbiter (
    input  logic cnt_eot,
    input  logic short_eot,
    input  logic dir_out,
    input  logic beat,
    input  logic ep_short,
    input  logic last,
    input  logic mid_after,
    output logic cnt_hit,
    output logic short_hit,
    output logic flush
);
    logic short_out, short_in;

    always_comb begin
        cnt_hit   = cnt_eot && beat && last;
        short_out = short_eot && dir_out && beat && ep_short;
        short_in  = short_eot && !dir_out && beat && last;
        short_hit = short_out || short_in;
        flush     = short_in && mid_after;
    end
endmodule

// File: rtl/dma_eot_engine.sv
module dma_eot_engine
    import dma_eot_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int MPS = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [3:0]    cfg_wdata,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          stat_clr_wr,
    input  logic [2:0]    stat_clr_data,
    input  logic          ep_req,
    input  logic          ep_short,
    output logic          ep_ack,
    output logic          ep_flush,
    output logic          mem_req,
    input  logic          mem_ack,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          busy,
    output logic [2:0]    status,
    output logic          irq
);
    dma_cfg_t      cfg_q, cfg_in;
    eot_stat_t     stat_q, stat_set, stat_clr;
    logic [CW-1:0] count_q;
    logic [AW-1:0] base_q;
    logic          start, beat, limited, exhausted, last, mid_after;
    logic          cnt_hit, short_hit, flush, eot, dis_evt;
    logic [1:0]    bytes;

    assign cfg_in = dma_cfg_t'(cfg_wdata);

    always_comb begin
        start    = cfg_wr && cfg_in.enable && !cfg_q.enable;
        limited  = cfg_q.cnt_eot || (cfg_q.short_eot && !cfg_q.dir_out);
        mem_req  = cfg_q.enable && ep_req && !exhausted;
        beat     = mem_req && mem_ack;
        ep_ack   = beat;
        eot      = cnt_hit || short_hit;
        dis_evt  = cfg_wr && !cfg_in.enable && cfg_q.enable && !eot;
        stat_set = '{disabled: dis_evt, short_pkt: short_hit, counter: cnt_hit};
        stat_clr = stat_clr_wr ? eot_stat_t'(stat_clr_data) : '0;
        busy     = cfg_q.enable;
        status   = stat_q;
    end

    dma_word_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(start), .load_val(count_q), .beat(beat),
        .limited(limited), .be(mem_be), .bytes(bytes), .last(last),
        .exhausted(exhausted)
    );

    dma_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .load(start), .base(base_q), .beat(beat),
        .addr(mem_addr)
    );

    dma_pkt_fill #(.MPS(MPS)) u_fill (
        .clk(clk), .rst(rst), .clear(start), .beat(beat), .bytes(bytes),
        .mid_after(mid_after)
    );

    dma_eot_arbiter u_arb (
        .cnt_eot(cfg_q.cnt_eot), .short_eot(cfg_q.short_eot),
        .dir_out(cfg_q.dir_out), .beat(beat), .ep_short(ep_short),
        .last(last), .mid_after(mid_after), .cnt_hit(cnt_hit),
        .short_hit(short_hit), .flush(flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            count_q  <= '0;
            base_q   <= '0;
            stat_q   <= '0;
            irq      <= 1'b0;
            ep_flush <= 1'b0;
        end else begin
            if (cfg_wr)
                cfg_q <= cfg_in;
            if (eot)
                cfg_q.enable <= 1'b0;
            if (cnt_wr)
                count_q <= cnt_wdata;
            if (base_wr)
                base_q <= base_wdata;
            stat_q   <= (stat_q & ~stat_clr) | stat_set;
            irq      <= eot;
            ep_flush <= flush;
        end
    end
endmodule

// File: rtl/dma_eot_checker.sv
module dma_eot_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_be,
    input logic          irq,
    input logic          ep_flush,
    input logic [2:0]    status
);
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + AW'(2)));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    a_r7_disable_silent: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> !irq);

    a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r8_irq_after_stop: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    a_r4_be_shape: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_be != 2'b11) |-> (mem_be == 2'b01));

    a_r6_flush_with_irq: assert property (@(posedge clk) disable iff (rst)
        ep_flush |-> (irq && status[1]));
endmodule

bind dma_eot_engine dma_eot_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_be(mem_be), .irq(irq), .ep_flush(ep_flush),
    .status(status)
);

// File: tb/dma_eot_engine_bench.sv
module dma_eot_engine_bench;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam logic [31:0] BASE = 32'h0000_1000;

    typedef struct packed {
        logic        cnt;
        logic        sht;
        logic        dout;
        logic [15:0] count;
        logic [15:0] short_at;
        logic [15:0] words;
        logic [2:0]  stat;
        logic [3:0]  irqs;
        logic [3:0]  flushes;
        logic [1:0]  be;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 16'd64,  16'hFFFF, 16'd32, 3'b001, 4'd1, 4'd0, 2'b11}, // R3
        '{1'b1, 1'b0, 1'b1, 16'd7,   16'hFFFF, 16'd4,  3'b001, 4'd1, 4'd0, 2'b01}, // R4
        '{1'b0, 1'b1, 1'b1, 16'd0,   16'd5,    16'd6,  3'b010, 4'd1, 4'd0, 2'b11}, // R5
        '{1'b1, 1'b1, 1'b1, 16'd10,  16'd4,    16'd5,  3'b011, 4'd1, 4'd0, 2'b11}, // R9
        '{1'b0, 1'b1, 1'b0, 16'd20,  16'hFFFF, 16'd10, 3'b010, 4'd1, 4'd1, 2'b11}, // R6
        '{1'b0, 1'b1, 1'b0, 16'd64,  16'hFFFF, 16'd32, 3'b010, 4'd1, 4'd0, 2'b11}, // R6
        '{1'b1, 1'b1, 1'b0, 16'd6,   16'hFFFF, 16'd3,  3'b011, 4'd1, 4'd1, 2'b11}, // R9
        '{1'b1, 1'b1, 1'b1, 16'd100, 16'd2,    16'd3,  3'b010, 4'd1, 4'd0, 2'b11}, // R5
        '{1'b0, 1'b1, 1'b0, 16'd7,   16'hFFFF, 16'd4,  3'b010, 4'd1, 4'd1, 2'b01}  // R4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_wdata = '0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          base_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic          stat_clr_wr = 1'b0;
    logic [2:0]    stat_clr_data = '0;
    logic          ep_req = 1'b0;
    logic          ep_short = 1'b0;
    logic          mem_ack = 1'b1;
    logic          ep_ack, ep_flush, mem_req, busy, irq;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic [2:0]    status;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dma_eot_engine #(.AW(AW), .CW(CW), .MPS(64)) u_dma_eot_engine (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .base_wr(base_wr),
        .base_wdata(base_wdata), .stat_clr_wr(stat_clr_wr),
        .stat_clr_data(stat_clr_data), .ep_req(ep_req), .ep_short(ep_short),
        .ep_ack(ep_ack), .ep_flush(ep_flush), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_be(mem_be),
        .busy(busy), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_base(input logic [31:0] v);
        @(negedge clk); base_wr = 1'b1; base_wdata = v;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic clr_stat(input logic [2:0] m);
        @(negedge clk); stat_clr_wr = 1'b1; stat_clr_data = m;
        @(negedge clk); stat_clr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int beats, irqs, fls, idle;
        logic [1:0] lastbe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 busy", busy, 0);
        chk("R11 irq", irq, 0);
        chk("R11 flush", ep_flush, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 status", status, 0);
        chk("R11 addr", mem_addr, 0);

        wr_base(BASE);
        for (int v = 0; v < NV; v++) begin
            clr_stat(3'b111);
            wr_cnt(VECS[v].count);
            wr_cfg({VECS[v].dout, VECS[v].sht, VECS[v].cnt, 1'b1});
            chk("R1 addr load", mem_addr, BASE);
            beats = 0; irqs = 0; fls = 0; idle = 0; lastbe = 2'b00;
            ep_req = 1'b1;
            for (int c = 0; c < 400 && idle < 3; c++) begin
                ep_short = (16'(beats) == VECS[v].short_at);
                #1;
                if (mem_req && mem_ack) begin beats++; lastbe = mem_be; end
                if (irq) irqs++;
                if (ep_flush) fls++;
                if (!busy) idle++;
                @(negedge clk);
            end
            ep_req = 1'b0; ep_short = 1'b0;
            chk("R3 R5 R6 beats", beats, VECS[v].words);
            chk("R3 R5 R6 R9 status", status, VECS[v].stat);
            chk("R8 R9 irq pulses", irqs, VECS[v].irqs);
            chk("R6 flush pulses", fls, VECS[v].flushes);
            chk("R4 last byte enables", lastbe, VECS[v].be);
            chk("R2 final addr", mem_addr, BASE + 2 * VECS[v].words);
        end

        // R2: stall while ep_req low, then exactly five beats
        clr_stat(3'b111);
        wr_cnt(16'd100);
        wr_cfg(4'b1011);
        repeat (3) @(negedge clk);
        chk("R2 no request without ep_req", mem_req, 0);
        chk("R2 addr held", mem_addr, BASE);
        ep_req = 1'b1;
        repeat (5) @(negedge clk);
        ep_req = 1'b0;
        chk("R2 five beats", mem_addr, BASE + 10);

        // R7: silent disable
        irqs = 0;
        wr_cfg(4'b1010);
        ep_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            #1;
            if (irq) irqs++;
            chk("R7 no request after disable", mem_req, 0);
            @(negedge clk);
        end
        ep_req = 1'b0;
        chk("R7 status disabled", status, 3'b100);
        chk("R7 no irq", irqs, 0);
        chk("R7 busy low", busy, 0);
        chk("R7 addr frozen", mem_addr, BASE + 10);

        // R10: selective write-one-to-clear
        clr_stat(3'b010);
        chk("R10 untouched bit stays", status, 3'b100);
        clr_stat(3'b100);
        chk("R10 bit cleared", status, 3'b000);

        // R10: set wins over clear on the same edge
        wr_cnt(16'd2);
        wr_cfg(4'b1011);
        @(negedge clk);
        ep_req = 1'b1; stat_clr_wr = 1'b1; stat_clr_data = 3'b001;
        @(negedge clk);
        ep_req = 1'b0; stat_clr_wr = 1'b0;
        chk("R10 set wins", status, 3'b001);
        chk("R8 irq after final beat", irq, 1);
        chk("R8 busy dropped", busy, 0);
        @(negedge clk);
        chk("R8 irq one cycle", irq, 0);

        // R1: reload from a new base on the next enable
        wr_base(32'h0000_2000);
        wr_cfg(4'b1011);
        chk("R1 reload base", mem_addr, 32'h0000_2000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule